// File: doc/BRIEF.md
# Programmable Input Deglitch Filter Bank

This block cleans up a bank of 24 slow digital inputs before the rest of the chip sees them. Every input first crosses into the clock domain through a two-flop synchronizer. A channel whose filter is switched on only passes a new level once that level has held steady for a programmable number of time-base ticks. A channel whose filter is switched off follows its synchronized input with no added delay. All filtering channels share one 20-bit interval. The time base is a single-cycle clock-enable strobe, `tick`, that comes from outside the block.

Software reaches the block through a byte-wide register port. An interval written to the staging bytes does nothing until a command byte copies it to the active interval. The same command byte has a second bit that resynchronizes the whole bank: every filtered output takes its current synchronized input, and every counter is cleared. The filtered vector can be read back one byte at a time, and it is also available in parallel.

Top module: `deglitch_bank`

## Requirements
- R1: After a synchronous reset, every filtered output is 0, every channel filter is disabled and the active interval is 0.
- R2: A channel whose enable bit is 0 shows a level applied to its input on the output after exactly 3 clock edges: two synchronizer stages and the output register.
- R3: A channel whose enable bit is 1, with active interval L>0 and `tick` high on every cycle, takes a new input level on the output at the edge 2+L after the level is applied. The level is not taken at any earlier edge. If the input returns to the output's level first, the count restarts and the output never moves.
- R4: The interval counter advances only on clock edges where `tick` is 1. With `tick` held low, an enabled channel's output stays put however long its input has differed.
- R5: The interval is staged by writes to addresses 0x08 (bits 7:0), 0x09 (bits 15:8) and 0x0A (bits 19:16 from data bits 3:0). Data bits 7:4 at 0x0A are ignored. Staged bytes do not change filtering until a write to 0x07 with data bit 0 set copies the staged value to the active interval.
- R6: The per-channel enables are written at 0x0C (channels 7:0), 0x0D (15:8) and 0x0E (23:16). A bit value of 1 turns that channel's filter on.
- R7: A write to 0x07 with data bit 1 set loads every filtered output with its synchronized input at that same edge and clears all counters.
- R8: When the active interval is 0, enabled channels behave exactly like disabled channels (R2).
- R9: `rd_data` is registered and reflects `rd_addr` one edge later. Addresses 0x00, 0x01 and 0x02 return filtered channels 7:0, 15:8 and 23:16, and every other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base clock enable; one pulse per interval count |
| raw_in | input | 24 | Asynchronous raw input levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write byte address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Read-back byte address |
| rd_data | output | 8 | Registered read-back byte of the filtered inputs |
| filt_out | output | 24 | Filtered input vector |

## Verification
The hardest case to reach from the ports is a glitch that lasts just under the interval while the per-channel counters are frozen by register writes. If the glitch is timed poorly, the counter crosses the limit during the two-cycle synchronizer lag on the way back, so the bench pins the glitch length and the number of write cycles around it. Exact interval timing is probed one edge below and one edge at the limit. This is done first with a staged but unloaded interval and then after the load, so the staging rule and the counting rule each show up as a one-cycle difference at `filt_out`. Tick gating, the ignored upper nibble and the resynchronize command are each driven into a state where the output would move only if that rule were broken.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;
  localparam int RD_BASE   = 'h00;
  localparam int CMD_ADDR  = 'h07;
  localparam int IVL_BASE  = 'h08;
  localparam int ENA_BASE  = 'h0C;
  localparam int CMD_LOAD  = 0;
  localparam int CMD_FLUSH = 1;

  function automatic int bytes_for(input int bits);
    return (bits + 7) / 8;
  endfunction
endpackage

// File: rtl/deglitch_regs.sv
module deglitch_regs
  import deglitch_pkg::*;
#(
  parameter int NCH = 24,
  parameter int IW  = 20,
  parameter int AW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [NCH-1:0] ena,
  output logic [IW-1:0]  active_ivl,
  output logic           flush
);
  logic [IW-1:0] staged_ivl;
  logic          cmd_hit;
  logic          load;

  assign cmd_hit = wr_en && (wr_addr == AW'(CMD_ADDR));
  assign load    = cmd_hit && wr_data[CMD_LOAD];
  assign flush   = cmd_hit && wr_data[CMD_FLUSH];

  for (genvar k = 0; k < IW; k++) begin : g_ivl
    always_ff @(posedge clk) begin
      if (rst) staged_ivl[k] <= 1'b0;
      else if (wr_en && wr_addr == AW'(IVL_BASE + k / 8)) staged_ivl[k] <= wr_data[k % 8];
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ena
    always_ff @(posedge clk) begin
      if (rst) ena[k] <= 1'b0;
      else if (wr_en && wr_addr == AW'(ENA_BASE + k / 8)) ena[k] <= wr_data[k % 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) active_ivl <= '0;
    else if (load) active_ivl <= staged_ivl;
  end

  // R1: reset clears enables and the active interval
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (ena == '0 && active_ivl == '0));
  // R5: the active interval moves only on a load command
  a_r5_stage_only: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(active_ivl));
endmodule

// File: rtl/deglitch_chan.sv
module deglitch_chan #(
  parameter int IW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_in,
  input  logic          en,
  input  logic          tick,
  input  logic [IW-1:0] lim,
  input  logic          flush,
  output logic          q
);
  logic [IW-1:0] cnt;
  logic [IW:0]   cnt_inc;
  logic          bypass;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign bypass  = !en || (lim == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (flush || bypass) begin
      q   <= sync_in;
      cnt <= '0;
    end else if (sync_in == q) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt_inc >= {1'b0, lim}) begin
        q   <= sync_in;
        cnt <= '0;
      end else begin
        cnt <= cnt_inc[IW-1:0];
      end
    end
  end

  // R2: a disabled channel follows its synchronized input
  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    (!en && !flush) |=> (q == $past(sync_in)));
  // R8: zero interval behaves as bypass
  a_r8_zero_ivl: assert property (@(posedge clk) disable iff (rst)
    (lim == '0 && !flush) |=> (q == $past(sync_in)));
  // R4: without a tick an enabled channel holds
  a_r4_tick_gate: assert property (@(posedge clk) disable iff (rst)
    (en && lim != '0 && !tick && !flush) |=> $stable(q));
  // R7: flush resynchronizes output and clears the count
  a_r7_flush: assert property (@(posedge clk) disable iff (rst)
    flush |=> (q == $past(sync_in) && cnt == '0));
endmodule

// File: rtl/deglitch_bank.sv
module deglitch_bank
  import deglitch_pkg::*;
#(
  parameter int NCH = 24,
  parameter int IW  = 20,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [NCH-1:0] raw_in,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [7:0]     rd_data,
  output logic [NCH-1:0] filt_out
);
  localparam int NB = bytes_for(NCH);

  logic [NCH-1:0]  meta_q, sync_q;
  logic [NCH-1:0]  ena;
  logic [IW-1:0]   active_ivl;
  logic            flush;
  logic [NB*8-1:0] filt_pad;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
    end
  end

  deglitch_regs #(.NCH(NCH), .IW(IW), .AW(AW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ena        (ena),
    .active_ivl (active_ivl),
    .flush      (flush)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    deglitch_chan #(.IW(IW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .sync_in (sync_q[c]),
      .en      (ena[c]),
      .tick    (tick),
      .lim     (active_ivl),
      .flush   (flush),
      .q       (filt_out[c])
    );
  end

  assign filt_pad = (NB*8)'(filt_out);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      for (int b = 0; b < NB; b++)
        if (rd_addr == AW'(RD_BASE + b)) rd_data <= filt_pad[b*8 +: 8];
    end
  end

  // R9: unmapped read addresses return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_addr) >= RD_BASE + NB) |=> (rd_data == 8'h00));
endmodule

// File: tb/deglitch_bank_test.sv
module deglitch_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [23:0] raw_in = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [23:0] filt_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  deglitch_bank uut (
    .clk(clk), .rst(rst), .tick(tick), .raw_in(raw_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .filt_out(filt_out)
  );

  typedef struct packed {
    logic [23:0] en;
    logic [23:0] din;
    logic [7:0]  hold;
    logic [23:0] exp;
  } vec_t;

  // interval 4, tick every cycle during holds
  localparam vec_t VEC [0:7] = '{
    '{24'h000000, 24'hA5A5A5, 8'd3, 24'hA5A5A5},
    '{24'h000000, 24'h123456, 8'd3, 24'h123456},
    '{24'hFFFFFF, 24'hFFFF00, 8'd5, 24'h123456},
    '{24'hFFFFFF, 24'hFFFF00, 8'd3, 24'hFFFF00},
    '{24'h00FF00, 24'h0000FF, 8'd3, 24'h00FFFF},
    '{24'h00FF00, 24'h0000FF, 8'd6, 24'h0000FF},
    '{24'hFFFFFF, 24'hFF00FF, 8'd3, 24'h0000FF},
    '{24'hFFFFFF, 24'h0000FF, 8'd8, 24'h0000FF}
  };

  task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_en(input logic [23:0] v);
    wr(5'h0C, v[7:0]); wr(5'h0D, v[15:8]); wr(5'h0E, v[23:16]);
  endtask

  task automatic set_ivl(input logic [23:0] v);
    wr(5'h08, v[7:0]); wr(5'h09, v[15:8]); wr(5'h0A, v[23:16]);
  endtask

  initial begin
    hold(3);
    chk("R1 reset filt_out", filt_out, 24'h0);
    chk("R1 reset rd_data", {16'h0, rd_data}, 24'h0);
    rst = 1'b0;
    set_ivl(24'h000004);
    wr(5'h07, 8'h01);

    for (int i = 0; i < 8; i++) begin
      tick = 1'b0;
      set_en(VEC[i].en);
      raw_in = VEC[i].din;
      tick = 1'b1;
      hold(int'(VEC[i].hold));
      chk($sformatf("R2 R3 R6 vector %0d", i), filt_out, VEC[i].exp);
    end

    // R5: staged interval 10 without load; active stays 4
    tick = 1'b0;
    set_ivl(24'h00000A);
    raw_in = 24'h00FF00; tick = 1'b1;
    hold(5); chk("R5 unloaded edge 5", filt_out, 24'h0000FF);
    hold(1); chk("R3 R5 unloaded edge 6", filt_out, 24'h00FF00);
    tick = 1'b0;
    wr(5'h07, 8'h01);
    raw_in = 24'hFFFFFF; tick = 1'b1;
    hold(11); chk("R5 loaded edge 11", filt_out, 24'h00FF00);
    hold(1);  chk("R5 loaded edge 12", filt_out, 24'hFFFFFF);

    // R5: upper nibble of the third interval byte ignored -> interval 2
    tick = 1'b0;
    set_ivl(24'hF00002);
    wr(5'h07, 8'h01);
    raw_in = 24'h000000; tick = 1'b1;
    hold(3); chk("R5 nibble edge 3", filt_out, 24'hFFFFFF);
    hold(1); chk("R5 nibble edge 4", filt_out, 24'h000000);

    // R4: no tick, no progress
    tick = 1'b0;
    raw_in = 24'hABCDEF;
    hold(20); chk("R4 no tick", filt_out, 24'h000000);
    tick = 1'b1; hold(1); tick = 1'b0;
    chk("R4 one tick", filt_out, 24'h000000);
    tick = 1'b1; hold(1); tick = 1'b0;
    chk("R4 second tick", filt_out, 24'hABCDEF);

    // R8: zero interval bypasses enabled channels
    set_ivl(24'h000000);
    wr(5'h07, 8'h01);
    raw_in = 24'h135790; tick = 1'b1;
    hold(3); chk("R8 zero interval", filt_out, 24'h135790);

    // R7: flush forces the synchronized input through
    tick = 1'b0;
    set_ivl(24'h000004);
    wr(5'h07, 8'h01);
    raw_in = 24'hFEDCBA; tick = 1'b1;
    hold(3); chk("R7 before flush", filt_out, 24'h135790);
    tick = 1'b0;
    wr(5'h07, 8'h02);
    chk("R7 after flush", filt_out, 24'hFEDCBA);

    // R9: read-back
    rd_addr = 5'h00; hold(1); chk("R9 byte 0", {16'h0, rd_data}, 24'h0000BA);
    rd_addr = 5'h01; hold(1); chk("R9 byte 1", {16'h0, rd_data}, 24'h0000DC);
    rd_addr = 5'h02; hold(1); chk("R9 byte 2", {16'h0, rd_data}, 24'h0000FE);
    rd_addr = 5'h07; hold(1); chk("R9 unmapped", {16'h0, rd_data}, 24'h000000);

    // R1: reset mid-run clears state; enables off afterwards
    rst = 1'b1; hold(2);
    chk("R1 mid reset", filt_out, 24'h000000);
    rst = 1'b0;
    raw_in = 24'h555555; tick = 1'b0;
    hold(3); chk("R1 R2 bypass after reset", filt_out, 24'h555555);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule